// File: doc/BRIEF.md
# Accumulator ALU with condition codes

This block is the execute slice for a subset of an 8-bit accumulator machine. For each accepted request it reads the opcode byte, the accumulator, a memory operand, the 16-bit index pair, the stack pointer, the program counter and the condition-code byte. It then computes the new accumulator or operand, the adjusted pointers, the new flags, the next program counter and the cycle cost of the instruction. Instruction fetch, operand address generation and bus timing belong to neighbouring blocks.

A request is presented with `valid_i` high for one clock. The results are registered on that rising edge and are held until the next request. `done_o` pulses alongside them. The supported opcodes are 0xAB/0xBB (add, immediate/direct), 0xA9/0xB9 (add with carry), 0xA4/0xB4 (logical and), 0x48/0x38 (shift left on accumulator/operand), 0x47/0x37 (arithmetic shift right on accumulator/operand), 0xA7 (stack pointer adjust), 0xAF (index adjust), 0x11+2n (clear bit n of the operand) and 0x24/0x25/0x27 (branch on carry clear, carry set, zero set).

The condition-code byte has this layout: bit 7 V (overflow), bit 4 H (half carry), bit 3 I (interrupt mask), bit 2 N (negative), bit 1 Z (zero), bit 0 C (carry). Bits 6 and 5 carry no flag.

Top module: `acc_alu_slice`

## Requirements
- R1: ADD (0xAB, 0xBB) writes A+M to the accumulator and ignores the incoming C. C is set to the carry out of bit 7, H to the carry out of bit 3, and V to signed overflow (both operands of equal sign and the result sign different).
- R2: ADC (0xA9, 0xB9) writes A+M+C to the accumulator. It sets C, H and V by the same rules as R1.
- R3: AND (0xA4, 0xB4) writes A&M to the accumulator and always clears V. H and C keep their incoming values.
- R4: Shift left (0x48 on the accumulator, 0x38 on the operand) moves b7 into C and 0 into b0, and sets V = N xor C. H is kept.
- R5: Arithmetic shift right (0x47 on the accumulator, 0x37 on the operand) moves b0 into C and keeps b7, and sets V = N xor C. H is kept.
- R6: For every add, and and shift operation, N equals bit 7 of the result and Z is set exactly when the 8-bit result is zero.
- R7: 0xA7 adds the operand, sign-extended to 16 bits, to SP, and 0xAF does the same to the index pair. Both wrap modulo 2^16 and leave the whole condition-code byte unchanged.
- R8: The branches 0x24 (C=0), 0x25 (C=1) and 0x27 (Z=1) produce PC+2+sext(operand) when their condition holds and PC+2 otherwise. The sum wraps modulo 2^16.
- R9: Opcode 0x11+2n (n = 0..7) clears bit n of the operand, leaves the other operand bits unchanged and leaves the condition-code byte unchanged.
- R10: The cycle output is 2 for immediate add/adc/and and for both pointer adjusts, and 3 for direct add/adc/and and for the branches. It is 1 for the accumulator shifts, and 4 for the operand shifts and for bit clear.
- R11: For all supported non-branch opcodes the next PC is PC+1 for the accumulator shifts and PC+2 for every other opcode.
- R12: No operation changes I or bits 6 and 5 of the condition-code byte.
- R13: Outputs that an operation does not write equal their inputs. An unsupported opcode passes every value through, leaves the PC unchanged and reports 0 cycles.
- R14: After reset all outputs are zero. Results appear at the first rising edge after `valid_i`, with `done_o` high for that one cycle, and are held while `valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Request strobe |
| opcode_i | input | 8 | Opcode byte |
| acc_i | input | 8 | Accumulator |
| mem_i | input | 8 | Memory operand, immediate or branch offset |
| hx_i | input | 16 | Index pair |
| sp_i | input | 16 | Stack pointer |
| pc_i | input | 16 | Address of the instruction |
| ccr_i | input | 8 | Condition-code byte |
| done_o | output | 1 | Result strobe |
| acc_o | output | 8 | New accumulator |
| mem_o | output | 8 | New memory operand |
| hx_o | output | 16 | New index pair |
| sp_o | output | 16 | New stack pointer |
| pc_o | output | 16 | Next program counter |
| ccr_o | output | 8 | New condition-code byte |
| cyc_o | output | 3 | Cycle cost of the instruction |

## Verification
Every result passes through exactly one register, so each result is due on the first rising edge after the request. The bench drives a request on a falling edge and holds `valid_i` for one period. It reads all outputs and `done_o` on the next falling edge, half a period after the capturing edge. Hold behaviour is checked on the falling edge after that, with `valid_i` low and changed inputs: the outputs must still show the previous result and `done_o` must be low.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  parameter int unsigned DW = 8;
  parameter int unsigned AW = 16;
  parameter int unsigned CW = 3;

  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_Z = 1;
  localparam int unsigned FLG_N = 2;
  localparam int unsigned FLG_I = 3;
  localparam int unsigned FLG_H = 4;
  localparam int unsigned FLG_V = 7;

  typedef enum logic [3:0] {
    OC_NONE, OC_ADD, OC_ADC, OC_AND, OC_ASL, OC_ASR,
    OC_AIS, OC_AIX, OC_BCLR, OC_BCC, OC_BCS, OC_BEQ
  } op_cls_e;

  typedef struct packed {
    op_cls_e        cls;
    logic           shf_mem;  // shift target: 1 = operand, 0 = accumulator
    logic [2:0]     bit_n;
    logic [1:0]     len;
    logic [CW-1:0]  cyc;
  } dec_t;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
  import acc_alu_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o = '{cls: OC_NONE, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd0, cyc: '0};
    unique case (opcode_i)
      8'hAB: dec_o = '{cls: OC_ADD, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(2)};
      8'hBB: dec_o = '{cls: OC_ADD, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(3)};
      8'hA9: dec_o = '{cls: OC_ADC, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(2)};
      8'hB9: dec_o = '{cls: OC_ADC, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(3)};
      8'hA4: dec_o = '{cls: OC_AND, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(2)};
      8'hB4: dec_o = '{cls: OC_AND, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(3)};
      8'h48: dec_o = '{cls: OC_ASL, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd1, cyc: CW'(1)};
      8'h38: dec_o = '{cls: OC_ASL, shf_mem: 1'b1, bit_n: 3'd0, len: 2'd2, cyc: CW'(4)};
      8'h47: dec_o = '{cls: OC_ASR, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd1, cyc: CW'(1)};
      8'h37: dec_o = '{cls: OC_ASR, shf_mem: 1'b1, bit_n: 3'd0, len: 2'd2, cyc: CW'(4)};
      8'hA7: dec_o = '{cls: OC_AIS, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(2)};
      8'hAF: dec_o = '{cls: OC_AIX, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(2)};
      8'h24: dec_o = '{cls: OC_BCC, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(3)};
      8'h25: dec_o = '{cls: OC_BCS, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(3)};
      8'h27: dec_o = '{cls: OC_BEQ, shf_mem: 1'b0, bit_n: 3'd0, len: 2'd2, cyc: CW'(3)};
      default: begin
        // bit clear: high nibble 1, odd low nibble; bits [3:1] select the bit
        if (opcode_i[7:4] == 4'h1 && opcode_i[0])
          dec_o = '{cls: OC_BCLR, shf_mem: 1'b1, bit_n: opcode_i[3:1], len: 2'd2, cyc: CW'(4)};
      end
    endcase
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = DW
) (
  input  op_cls_e      cls_i,
  input  logic         shf_mem_i,
  input  logic [2:0]   bit_n_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] m_i,
  input  logic [7:0]   ccr_i,
  output logic [W-1:0] acc_o,
  output logic [W-1:0] mem_o,
  output logic [7:0]   ccr_o
);
  localparam int unsigned NIB = W / 2;

  logic [W-1:0] clr_mask;
  genvar gi;
  generate
    for (gi = 0; gi < W; gi++) begin : g_mask
      assign clr_mask[gi] = (bit_n_i != 3'(gi));
    end
  endgenerate

  logic         cin;
  logic [W:0]   sum;
  logic [NIB:0] nib;
  logic [W-1:0] opnd, res;
  logic         upd_nz;

  assign cin  = (cls_i == OC_ADC) ? ccr_i[FLG_C] : 1'b0;
  assign sum  = {1'b0, a_i} + {1'b0, m_i} + {{W{1'b0}}, cin};
  assign nib  = {1'b0, a_i[NIB-1:0]} + {1'b0, m_i[NIB-1:0]} + {{NIB{1'b0}}, cin};
  assign opnd = shf_mem_i ? m_i : a_i;

  always_comb begin
    acc_o  = a_i;
    mem_o  = m_i;
    ccr_o  = ccr_i;
    res    = '0;
    upd_nz = 1'b0;
    unique case (cls_i)
      OC_ADD, OC_ADC: begin
        res          = sum[W-1:0];
        acc_o        = res;
        upd_nz       = 1'b1;
        ccr_o[FLG_C] = sum[W];
        ccr_o[FLG_H] = nib[NIB];
        ccr_o[FLG_V] = (a_i[W-1] == m_i[W-1]) && (res[W-1] != a_i[W-1]);
      end
      OC_AND: begin
        res          = a_i & m_i;
        acc_o        = res;
        upd_nz       = 1'b1;
        ccr_o[FLG_V] = 1'b0;
      end
      OC_ASL: begin
        res          = {opnd[W-2:0], 1'b0};
        upd_nz       = 1'b1;
        ccr_o[FLG_C] = opnd[W-1];
        ccr_o[FLG_V] = res[W-1] ^ opnd[W-1];
        if (shf_mem_i) mem_o = res;
        else           acc_o = res;
      end
      OC_ASR: begin
        res          = {opnd[W-1], opnd[W-1:1]};
        upd_nz       = 1'b1;
        ccr_o[FLG_C] = opnd[0];
        ccr_o[FLG_V] = res[W-1] ^ opnd[0];
        if (shf_mem_i) mem_o = res;
        else           acc_o = res;
      end
      OC_BCLR: mem_o = m_i & clr_mask;
      default: ;
    endcase
    if (upd_nz) begin
      ccr_o[FLG_N] = res[W-1];
      ccr_o[FLG_Z] = (res == '0);
    end
  end
endmodule

// File: rtl/acc_alu_addr.sv
module acc_alu_addr
  import acc_alu_pkg::*;
#(
  parameter int unsigned W  = DW,
  parameter int unsigned AWD = AW
) (
  input  op_cls_e        cls_i,
  input  logic [1:0]     len_i,
  input  logic [W-1:0]   imm_i,
  input  logic [AWD-1:0] hx_i,
  input  logic [AWD-1:0] sp_i,
  input  logic [AWD-1:0] pc_i,
  input  logic           c_i,
  input  logic           z_i,
  output logic [AWD-1:0] hx_o,
  output logic [AWD-1:0] sp_o,
  output logic [AWD-1:0] pc_o
);
  localparam int unsigned EXT = AWD - W;

  logic [AWD-1:0] sext, seq_pc, tgt_pc;
  logic           taken;

  assign sext   = {{EXT{imm_i[W-1]}}, imm_i};
  assign seq_pc = pc_i + AWD'(len_i);
  assign tgt_pc = seq_pc + sext;  // branch length is 2, so seq_pc = PC+2

  always_comb begin
    unique case (cls_i)
      OC_BCC:  taken = !c_i;
      OC_BCS:  taken = c_i;
      OC_BEQ:  taken = z_i;
      default: taken = 1'b0;
    endcase
  end

  always_comb begin
    hx_o = hx_i;
    sp_o = sp_i;
    pc_o = taken ? tgt_pc : seq_pc;
    if (cls_i == OC_AIS) sp_o = sp_i + sext;
    if (cls_i == OC_AIX) hx_o = hx_i + sext;
  end
endmodule

// File: rtl/acc_alu_slice.sv
module acc_alu_slice
  import acc_alu_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [7:0]    opcode_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] mem_i,
  input  logic [AW-1:0] hx_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] pc_i,
  input  logic [7:0]    ccr_i,
  output logic          done_o,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] mem_o,
  output logic [AW-1:0] hx_o,
  output logic [AW-1:0] sp_o,
  output logic [AW-1:0] pc_o,
  output logic [7:0]    ccr_o,
  output logic [CW-1:0] cyc_o
);
  dec_t          dec;
  logic [DW-1:0] acc_d, mem_d;
  logic [AW-1:0] hx_d, sp_d, pc_d;
  logic [7:0]    ccr_d;

  acc_alu_decode u_dec (.opcode_i(opcode_i), .dec_o(dec));

  acc_alu_logic #(.W(DW)) u_logic (
    .cls_i(dec.cls), .shf_mem_i(dec.shf_mem), .bit_n_i(dec.bit_n),
    .a_i(acc_i), .m_i(mem_i), .ccr_i(ccr_i),
    .acc_o(acc_d), .mem_o(mem_d), .ccr_o(ccr_d)
  );

  acc_alu_addr #(.W(DW), .AWD(AW)) u_addr (
    .cls_i(dec.cls), .len_i(dec.len), .imm_i(mem_i),
    .hx_i(hx_i), .sp_i(sp_i), .pc_i(pc_i),
    .c_i(ccr_i[FLG_C]), .z_i(ccr_i[FLG_Z]),
    .hx_o(hx_d), .sp_o(sp_d), .pc_o(pc_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      acc_o  <= '0;
      mem_o  <= '0;
      hx_o   <= '0;
      sp_o   <= '0;
      pc_o   <= '0;
      ccr_o  <= '0;
      cyc_o  <= '0;
    end else begin
      done_o <= valid_i;
      if (valid_i) begin
        acc_o <= acc_d;
        mem_o <= mem_d;
        hx_o  <= hx_d;
        sp_o  <= sp_d;
        pc_o  <= pc_d;
        ccr_o <= ccr_d;
        cyc_o <= dec.cyc;
      end
    end
  end

  AST_DONE_AFTER_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(valid_i)); // R14
  AST_I_FLAG_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ccr_o[FLG_I] == $past(ccr_i[FLG_I])) && (ccr_o[6:5] == $past(ccr_i[6:5]))); // R12
  AST_PTR_CCR_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(opcode_i) == 8'hA7 || $past(opcode_i) == 8'hAF)) |-> ccr_o == $past(ccr_i)); // R7
  AST_AND_V_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(opcode_i) == 8'hA4 || $past(opcode_i) == 8'hB4)) |-> !ccr_o[FLG_V]); // R3
  AST_BRANCH_CYCLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ($past(opcode_i) == 8'h24 || $past(opcode_i) == 8'h25 || $past(opcode_i) == 8'h27))
      |-> cyc_o == CW'(3)); // R10
  AST_BCLR_ONE_BIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(opcode_i[7:4]) == 4'h1 && $past(opcode_i[0]))
      |-> ($countones($past(mem_i) ^ mem_o) <= 1) && ((mem_o & ~$past(mem_i)) == '0)
          && ccr_o == $past(ccr_i)); // R9
  AST_UNSUPPORTED_PC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cyc_o == '0) |-> pc_o == $past(pc_i) && acc_o == $past(acc_i)); // R13
endmodule

// File: tb/acc_alu_slice_bench.sv
module acc_alu_slice_bench;
  localparam time CLK_P = 10ns;

  logic        clk = 1'b0, rst_n = 1'b0, valid = 1'b0;
  logic [7:0]  opc = '0, acc = '0, mem = '0, ccr = '0;
  logic [15:0] hx = '0, sp = '0, pc = '0;
  logic        done;
  logic [7:0]  acc_q, mem_q, ccr_q;
  logic [15:0] hx_q, sp_q, pc_q;
  logic [2:0]  cyc_q;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  acc_alu_slice u_acc_alu_slice (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .opcode_i(opc),
    .acc_i(acc), .mem_i(mem), .hx_i(hx), .sp_i(sp), .pc_i(pc), .ccr_i(ccr),
    .done_o(done), .acc_o(acc_q), .mem_o(mem_q), .hx_o(hx_q), .sp_o(sp_q),
    .pc_o(pc_q), .ccr_o(ccr_q), .cyc_o(cyc_q)
  );

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive on falling edge, result registered on next rising edge, sample at following falling edge
  task automatic apply(logic [7:0] o, logic [7:0] a, logic [7:0] m, logic [15:0] h,
                       logic [15:0] s, logic [15:0] p, logic [7:0] c);
    @(negedge clk);
    opc = o; acc = a; mem = m; hx = h; sp = s; pc = p; ccr = c; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
  endtask

  task automatic expect_all(string tag, logic [7:0] ea, logic [7:0] em, logic [15:0] eh,
                            logic [15:0] es, logic [15:0] ep, logic [7:0] ec, logic [2:0] ey);
    chk("R14", "done", 16'(done), 16'h1);
    chk(tag, "acc", 16'(acc_q), 16'(ea));
    chk(tag, "mem", 16'(mem_q), 16'(em));
    chk(tag, "hx", hx_q, eh);
    chk(tag, "sp", sp_q, es);
    chk(tag, "pc", pc_q, ep);
    chk(tag, "ccr", 16'(ccr_q), 16'(ec));
    chk("R10", "cyc", 16'(cyc_q), 16'(ey));
  endtask

  task automatic t_reset;
    chk("R14", "reset done", 16'(done), 16'h0);
    chk("R14", "reset acc", 16'(acc_q), 16'h0);
    chk("R14", "reset pc", pc_q, 16'h0);
    chk("R14", "reset ccr", 16'(ccr_q), 16'h0);
  endtask

  task automatic t_add;
    apply(8'hAB, 8'h7F, 8'h01, 16'h1234, 16'h00FF, 16'h0100, 8'h68);
    expect_all("R1", 8'h80, 8'h01, 16'h1234, 16'h00FF, 16'h0102, 8'hFC, 3'd2);
    apply(8'hBB, 8'h10, 8'h20, 16'h1234, 16'h00FF, 16'h0200, 8'h61);  // C in ignored
    expect_all("R1", 8'h30, 8'h20, 16'h1234, 16'h00FF, 16'h0202, 8'h60, 3'd3);
  endtask

  task automatic t_adc;
    apply(8'hA9, 8'hFF, 8'h00, 16'h0, 16'h0, 16'h0300, 8'h61);
    expect_all("R2", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0302, 8'h73, 3'd2);
    apply(8'hB9, 8'h40, 8'h3F, 16'h0, 16'h0, 16'h0300, 8'h61);
    expect_all("R2", 8'h80, 8'h3F, 16'h0, 16'h0, 16'h0302, 8'hF4, 3'd3);
  endtask

  task automatic t_and;
    apply(8'hA4, 8'hF0, 8'h0F, 16'h0, 16'h0, 16'h0400, 8'hF1);
    expect_all("R3", 8'h00, 8'h0F, 16'h0, 16'h0, 16'h0402, 8'h73, 3'd2);
    apply(8'hB4, 8'hC3, 8'h81, 16'h0, 16'h0, 16'h0400, 8'hE8);  // R6 N set
    expect_all("R6", 8'h81, 8'h81, 16'h0, 16'h0, 16'h0402, 8'h6C, 3'd3);
  endtask

  task automatic t_asl;
    apply(8'h48, 8'h81, 8'h33, 16'h0, 16'h0, 16'h0500, 8'h60);
    expect_all("R4", 8'h02, 8'h33, 16'h0, 16'h0, 16'h0501, 8'hE1, 3'd1);  // R11 +1
    apply(8'h38, 8'h55, 8'h40, 16'h0, 16'h0, 16'h0500, 8'h70);
    expect_all("R4", 8'h55, 8'h80, 16'h0, 16'h0, 16'h0502, 8'hF4, 3'd4);
  endtask

  task automatic t_asr;
    apply(8'h47, 8'h01, 8'h00, 16'h0, 16'h0, 16'h0600, 8'h60);
    expect_all("R5", 8'h00, 8'h00, 16'h0, 16'h0, 16'h0601, 8'hE3, 3'd1);
    apply(8'h37, 8'h11, 8'h81, 16'h0, 16'h0, 16'h0600, 8'h60);
    expect_all("R5", 8'h11, 8'hC0, 16'h0, 16'h0, 16'h0602, 8'h65, 3'd4);
  endtask

  task automatic t_ptr;
    apply(8'hAF, 8'h00, 8'hFF, 16'h0000, 16'h00F0, 16'h0700, 8'h9B);
    expect_all("R7", 8'h00, 8'hFF, 16'hFFFF, 16'h00F0, 16'h0702, 8'h9B, 3'd2);
    apply(8'hA7, 8'h00, 8'h7F, 16'h0000, 16'h00F0, 16'h0700, 8'h64);
    expect_all("R7", 8'h00, 8'h7F, 16'h0000, 16'h016F, 16'h0702, 8'h64, 3'd2);
    apply(8'hA7, 8'h00, 8'h80, 16'h0000, 16'h0010, 16'h0700, 8'h64);
    expect_all("R7", 8'h00, 8'h80, 16'h0000, 16'hFF90, 16'h0702, 8'h64, 3'd2);
  endtask

  task automatic t_branch;
    apply(8'h24, 8'h00, 8'hFE, 16'h0, 16'h0, 16'h1000, 8'h60);
    expect_all("R8", 8'h00, 8'hFE, 16'h0, 16'h0, 16'h1000, 8'h60, 3'd3);
    apply(8'h24, 8'h00, 8'hFE, 16'h0, 16'h0, 16'h1000, 8'h61);
    expect_all("R8", 8'h00, 8'hFE, 16'h0, 16'h0, 16'h1002, 8'h61, 3'd3);
    apply(8'h25, 8'h00, 8'h10, 16'h0, 16'h0, 16'h1000, 8'h60);
    expect_all("R8", 8'h00, 8'h10, 16'h0, 16'h0, 16'h1002, 8'h60, 3'd3);
    apply(8'h25, 8'h00, 8'h10, 16'h0, 16'h0, 16'h1000, 8'h61);
    expect_all("R8", 8'h00, 8'h10, 16'h0, 16'h0, 16'h1012, 8'h61, 3'd3);
    apply(8'h27, 8'h00, 8'h10, 16'h0, 16'h0, 16'hFFF0, 8'h62);  // wraps
    expect_all("R8", 8'h00, 8'h10, 16'h0, 16'h0, 16'h0002, 8'h62, 3'd3);
    apply(8'h27, 8'h00, 8'h10, 16'h0, 16'h0, 16'hFFF0, 8'h61);
    expect_all("R8", 8'h00, 8'h10, 16'h0, 16'h0, 16'hFFF2, 8'h61, 3'd3);
  endtask

  task automatic t_bclr;
    apply(8'h1B, 8'h44, 8'hFF, 16'h0, 16'h0, 16'h2000, 8'h6F);
    expect_all("R9", 8'h44, 8'hDF, 16'h0, 16'h0, 16'h2002, 8'h6F, 3'd4);
    apply(8'h11, 8'h44, 8'h01, 16'h0, 16'h0, 16'h2000, 8'h00);
    expect_all("R9", 8'h44, 8'h00, 16'h0, 16'h0, 16'h2002, 8'h00, 3'd4);
    apply(8'h1F, 8'h44, 8'hFF, 16'h0, 16'h0, 16'h2000, 8'h00);
    expect_all("R9", 8'h44, 8'h7F, 16'h0, 16'h0, 16'h2002, 8'h00, 3'd4);
  endtask

  task automatic t_unsupported;
    apply(8'h10, 8'h5A, 8'hA5, 16'h1111, 16'h2222, 16'h3333, 8'h8F);
    expect_all("R13", 8'h5A, 8'hA5, 16'h1111, 16'h2222, 16'h3333, 8'h8F, 3'd0);
  endtask

  task automatic t_hold;
    apply(8'hAB, 8'h01, 8'h02, 16'h0, 16'h0, 16'h0010, 8'h00);
    opc = 8'h48; acc = 8'hFF; mem = 8'hFF; pc = 16'hABCD;
    @(negedge clk);
    chk("R14", "hold done", 16'(done), 16'h0);
    chk("R14", "hold acc", 16'(acc_q), 16'h0003);
    chk("R14", "hold pc", pc_q, 16'h0012);
    chk("R14", "hold cyc", 16'(cyc_q), 16'h0002);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    #(CLK_P * 2 + CLK_P / 4);
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_add();
    t_adc();
    t_and();
    t_asl();
    t_asr();
    t_ptr();
    t_branch();
    t_bclr();
    t_unsupported();
    t_hold();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule